// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block is the coherence state machine of one private cache sitting on a shared snooping bus. It holds a five-state code (Modified, Owned, Exclusive, Shared, Invalid) for each line in a small set. The data arrays, the replacement choice and memory timing are handled elsewhere. Here only state codes, bus commands and the data-supply and sharing flags are produced.

The processor side presents one read, write or evict request at a time. Hits, silent promotions and silent drops complete without bus traffic. Misses, upgrades of shared lines and evictions of dirty lines place a single transaction on the bus. That transaction stays posted until the arbiter grants it. In parallel, the controller watches transactions issued by other caches. It invalidates or downgrades lines in response. When this cache holds a dirty line, it raises a flag so that it supplies the data instead of memory.

A line in Owned stays dirty while other caches also hold copies, and this cache remains the supplier for it. A line in Exclusive turns Modified on a local write with no bus cycle.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset, every line reads Invalid (state codes I=0, S=1, E=2, O=3, M=4, line i at line_state_o[3i+2:3i]), bus_cmd_o is idle (0), req_ready_o is high and req_done_o is low.
- R2: A read (req_op_i=0) of a valid line completes with no bus command. A read of an Invalid line posts a bus read (cmd 1). At the grant, the line becomes Exclusive if bus_shared_i is low and Shared if it is high. req_done_o pulses for one cycle on the cycle after acceptance or grant.
- R3: A write (req_op_i=1) to an Exclusive line makes it Modified with no bus command. A write to a Modified line leaves it Modified.
- R4: A write to a Shared or Owned line posts an upgrade-invalidate (cmd 3). A write to an Invalid line posts a read-exclusive (cmd 2). Either one makes the line Modified at the grant.
- R5: An evict (req_op_i=2) of a Modified or Owned line posts a writeback (cmd 4), and the line becomes Invalid at the grant. An evict of an Exclusive, Shared or Invalid line makes it Invalid with no bus command.
- R6: A snooped read (snoop_cmd_i=1) moves Modified to Owned and Exclusive to Shared, and leaves Owned and Shared unchanged. It raises snoop_supply_o in the same cycle when the line is Modified or Owned.
- R7: A snooped read-exclusive (2) or upgrade (3) makes the line Invalid. Only a read-exclusive hitting Modified or Owned raises snoop_supply_o. A snooped writeback (4) changes nothing. snoop_shared_o is high while a snooped read or read-exclusive hits a non-Invalid line.
- R8: Only one transaction is outstanding at a time. While one is posted, req_ready_o is low, requests are ignored, and bus_cmd_o and bus_idx_o hold until the grant.
- R9: A snoop to the line of a posted transaction is applied first, in bus order. An upgrade whose line is invalidated becomes a read-exclusive. A writeback whose line is invalidated is withdrawn and completes. A writeback whose line is downgraded from Modified to Owned stays posted.
- R10: A snoop to the same line in the cycle a request is accepted takes effect before the request is decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor request present |
| req_op_i | input | 2 | 0 read, 1 write, 2 evict |
| req_idx_i | input | IdxW | Line index of the request |
| req_ready_o | output | 1 | No transaction outstanding; a request is taken |
| req_done_o | output | 1 | One-cycle completion pulse |
| bus_cmd_o | output | 3 | 0 idle, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_idx_o | output | IdxW | Line index of the posted command |
| bus_grant_i | input | 1 | Posted command is performed this cycle |
| bus_shared_i | input | 1 | Another cache holds the line (sampled at grant) |
| snoop_valid_i | input | 1 | Another cache's transaction is on the bus |
| snoop_cmd_i | input | 3 | Snooped command, same encoding as bus_cmd_o |
| snoop_idx_i | input | IdxW | Line index of the snooped command |
| snoop_supply_o | output | 1 | This cache supplies the data, not memory |
| snoop_shared_o | output | 1 | This cache holds a copy of the snooped line |
| line_state_o | output | 3*NUM_LINES | State code of every line |

## Verification
The bench targets the races around a posted transaction. These are an upgrade that loses its shared copy to a remote invalidation, and a writeback that a remote read-exclusive makes pointless. A design that got these wrong would grant Modified from a stale upgrade or write back a line it no longer owns. The bench also collides a snoop with a request for the same line in the acceptance cycle. A design that decided on the old state would skip the upgrade and silently claim Modified over a remote copy. Snooped reads on Modified and Owned lines are checked for the supply flag. A design that dropped it would let memory return stale data.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4
  } line_st_t;

  typedef enum logic [2:0] {
    BC_IDLE = 3'd0, BC_RD = 3'd1, BC_RDX = 3'd2, BC_UPG = 3'd3, BC_WB = 3'd4
  } bus_cmd_t;

  typedef enum logic [1:0] {
    OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2, OP_RSV = 2'd3
  } req_op_t;
endpackage

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
  import moesi_pkg::*;
(
  input  line_st_t cur_i,
  input  logic     valid_i,
  input  logic [2:0] cmd_i,
  output line_st_t nxt_o,
  output logic     supply_o,
  output logic     shared_o
);
  logic dirty, held;
  assign dirty = (cur_i == ST_M) || (cur_i == ST_O);
  assign held  = (cur_i != ST_I);

  always_comb begin
    nxt_o    = cur_i;
    supply_o = 1'b0;
    shared_o = 1'b0;
    if (valid_i) begin
      unique case (cmd_i)
        3'(BC_RD): begin
          supply_o = dirty;
          shared_o = held;
          if (cur_i == ST_M) nxt_o = ST_O;
          else if (cur_i == ST_E) nxt_o = ST_S;
        end
        3'(BC_RDX): begin
          supply_o = dirty;
          shared_o = held;
          nxt_o    = ST_I;
        end
        3'(BC_UPG): nxt_o = ST_I;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/moesi_local_resp.sv
module moesi_local_resp
  import moesi_pkg::*;
(
  input  line_st_t   cur_i,
  input  logic [1:0] op_i,
  output line_st_t   nxt_o,
  output logic       need_bus_o,
  output bus_cmd_t   cmd_o
);
  always_comb begin
    nxt_o      = cur_i;
    need_bus_o = 1'b0;
    cmd_o      = BC_IDLE;
    unique case (op_i)
      2'(OP_WR): begin
        unique case (cur_i)
          ST_M, ST_E: nxt_o = ST_M;  // E promotes silently
          ST_S, ST_O: begin need_bus_o = 1'b1; cmd_o = BC_UPG; end
          default:    begin need_bus_o = 1'b1; cmd_o = BC_RDX; end
        endcase
      end
      2'(OP_EV): begin
        if (cur_i == ST_M || cur_i == ST_O) begin
          need_bus_o = 1'b1;
          cmd_o      = BC_WB;
        end else begin
          nxt_o = ST_I;
        end
      end
      default: begin  // read, reserved code treated as read
        if (cur_i == ST_I) begin
          need_bus_o = 1'b1;
          cmd_o      = BC_RD;
        end
      end
    endcase
  end
endmodule

// File: rtl/moesi_state_array.sv
module moesi_state_array
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 snp_we_i,
  input  logic [IDX_W-1:0]     snp_idx_i,
  input  line_st_t             snp_st_i,
  input  logic                 loc_we_i,
  input  logic [IDX_W-1:0]     loc_idx_i,
  input  line_st_t             loc_st_i,
  output line_st_t [NUM_LINES-1:0] st_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    // local write already folds in a same-cycle snoop, so it wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_o[g] <= ST_I;
      end else if (loc_we_i && (int'(loc_idx_i) == g)) begin
        st_o[g] <= loc_st_i;
      end else if (snp_we_i && (int'(snp_idx_i) == g)) begin
        st_o[g] <= snp_st_i;
      end
    end
  end
endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IdxW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [1:0]             req_op_i,
  input  logic [IdxW-1:0]        req_idx_i,
  output logic                   req_ready_o,
  output logic                   req_done_o,
  output logic [2:0]             bus_cmd_o,
  output logic [IdxW-1:0]        bus_idx_o,
  input  logic                   bus_grant_i,
  input  logic                   bus_shared_i,
  input  logic                   snoop_valid_i,
  input  logic [2:0]             snoop_cmd_i,
  input  logic [IdxW-1:0]        snoop_idx_i,
  output logic                   snoop_supply_o,
  output logic                   snoop_shared_o,
  output logic [3*NUM_LINES-1:0] line_state_o
);
  line_st_t [NUM_LINES-1:0] st;
  line_st_t snp_nxt, eff_st, lr_nxt, grant_st, loc_st;
  bus_cmd_t lr_cmd, pend_cmd_q;
  logic     lr_bus, busy_q, done_q, accept, granted, pend_hit, wb_cancel, loc_we;
  logic [IdxW-1:0] pend_idx_q, loc_idx;

  moesi_snoop_resp u_snoop (
    .cur_i    (st[snoop_idx_i]),
    .valid_i  (snoop_valid_i),
    .cmd_i    (snoop_cmd_i),
    .nxt_o    (snp_nxt),
    .supply_o (snoop_supply_o),
    .shared_o (snoop_shared_o)
  );

  // bus order: a snoop in the same cycle lands before the local decision
  assign eff_st = (snoop_valid_i && snoop_idx_i == req_idx_i) ? snp_nxt : st[req_idx_i];

  moesi_local_resp u_local (
    .cur_i      (eff_st),
    .op_i       (req_op_i),
    .nxt_o      (lr_nxt),
    .need_bus_o (lr_bus),
    .cmd_o      (lr_cmd)
  );

  assign accept   = req_valid_i && !busy_q;
  assign granted  = busy_q && bus_grant_i;
  assign pend_hit = busy_q && !bus_grant_i && snoop_valid_i &&
                    (snoop_idx_i == pend_idx_q) && (snp_nxt == ST_I);
  assign wb_cancel = pend_hit && (pend_cmd_q == BC_WB);

  always_comb begin
    unique case (pend_cmd_q)
      BC_RD:          grant_st = bus_shared_i ? ST_S : ST_E;
      BC_RDX, BC_UPG: grant_st = ST_M;
      default:        grant_st = ST_I;
    endcase
  end

  assign loc_we  = granted || (accept && !lr_bus);
  assign loc_idx = busy_q ? pend_idx_q : req_idx_i;
  assign loc_st  = busy_q ? grant_st : lr_nxt;

  moesi_state_array #(.NUM_LINES(NUM_LINES), .IDX_W(IdxW)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .snp_we_i  (snoop_valid_i),
    .snp_idx_i (snoop_idx_i),
    .snp_st_i  (snp_nxt),
    .loc_we_i  (loc_we),
    .loc_idx_i (loc_idx),
    .loc_st_i  (loc_st),
    .st_o      (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pend_cmd_q <= BC_IDLE;
      pend_idx_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= (accept && !lr_bus) || granted || wb_cancel;
      if (!busy_q) begin
        if (accept && lr_bus) begin
          busy_q     <= 1'b1;
          pend_cmd_q <= lr_cmd;
          pend_idx_q <= req_idx_i;
        end
      end else if (bus_grant_i) begin
        busy_q     <= 1'b0;
        pend_cmd_q <= BC_IDLE;
      end else if (pend_hit) begin
        if (pend_cmd_q == BC_UPG) pend_cmd_q <= BC_RDX;  // lost the shared copy
        else if (pend_cmd_q == BC_WB) begin
          busy_q     <= 1'b0;
          pend_cmd_q <= BC_IDLE;
        end
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign req_done_o  = done_q;
  assign bus_cmd_o   = busy_q ? 3'(pend_cmd_q) : 3'(BC_IDLE);
  assign bus_idx_o   = pend_idx_q;
  assign line_state_o = st;
endmodule

// File: rtl/moesi_line_ctrl_chk.sv
module moesi_line_ctrl_chk #(
  parameter int NUM_LINES = 8,
  localparam int IdxW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic                   req_ready_o,
  input logic                   req_done_o,
  input logic [2:0]             bus_cmd_o,
  input logic [IdxW-1:0]        bus_idx_o,
  input logic                   bus_grant_i,
  input logic                   snoop_valid_i,
  input logic [2:0]             snoop_cmd_i,
  input logic [IdxW-1:0]        snoop_idx_i,
  input logic                   snoop_supply_o,
  input logic [3*NUM_LINES-1:0] line_state_o
);
  // R8
  idle_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> bus_cmd_o == 3'd0);

  // R8
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 3'd0 && !bus_grant_i && !snoop_valid_i)
      |=> ($stable(bus_cmd_o) && $stable(bus_idx_o)));

  // R2
  done_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cmd_o != 3'd0 && bus_grant_i) |=> req_done_o);

  // R7
  supply_needs_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_supply_o |-> (snoop_valid_i && (snoop_cmd_i == 3'd1 || snoop_cmd_i == 3'd2)));

  // R6
  m_to_o_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_valid_i && snoop_cmd_i == 3'd1 && !bus_grant_i &&
     !(req_valid_i && req_ready_o) &&
     line_state_o[int'(snoop_idx_i)*3 +: 3] == 3'd4)
      |=> line_state_o[int'($past(snoop_idx_i))*3 +: 3] == 3'd3);
endmodule

bind moesi_line_ctrl moesi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_done_o     (req_done_o),
  .bus_cmd_o      (bus_cmd_o),
  .bus_idx_o      (bus_idx_o),
  .bus_grant_i    (bus_grant_i),
  .snoop_valid_i  (snoop_valid_i),
  .snoop_cmd_i    (snoop_cmd_i),
  .snoop_idx_i    (snoop_idx_i),
  .snoop_supply_o (snoop_supply_o),
  .line_state_o   (line_state_o)
);

// File: tb/moesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_line_ctrl_tb_top;
  localparam int NL = 8;
  localparam int IW = 3;
  localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rv = 0, gnt = 0, shr = 0, sv = 0;
  logic [1:0] rop = 0;
  logic [2:0] scmd = 0;
  logic [IW-1:0] ridx = 0, sidx = 0;
  logic ready, done, supply, shared;
  logic [2:0] bcmd;
  logic [IW-1:0] bidx;
  logic [3*NL-1:0] lst;

  int errors = 0, checks = 0;
  int mst[NL];
  int mbusy, mcmd, midx, mdone;

  always #10 clk = ~clk;

  moesi_line_ctrl #(.NUM_LINES(NL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(rv), .req_op_i(rop), .req_idx_i(ridx),
    .req_ready_o(ready), .req_done_o(done),
    .bus_cmd_o(bcmd), .bus_idx_o(bidx),
    .bus_grant_i(gnt), .bus_shared_i(shr),
    .snoop_valid_i(sv), .snoop_cmd_i(scmd), .snoop_idx_i(sidx),
    .snoop_supply_o(supply), .snoop_shared_o(shared),
    .line_state_o(lst)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int line(input int i);
    return int'(lst[i*3 +: 3]);
  endfunction

  function automatic int snp_next(input int st, input int c);
    if (c == 1) return (st == SM) ? SO : (st == SE) ? SS : st;
    if (c == 2 || c == 3) return SI;
    return st;
  endfunction

  task automatic compare_all();
    bit dirty, rd;
    rd    = sv && (scmd == 1 || scmd == 2);
    dirty = (mst[sidx] == SM || mst[sidx] == SO);
    chk("R6 R7 snoop_supply_o", supply, int'(rd && dirty));
    chk("R7 snoop_shared_o", shared, int'(rd && mst[sidx] != SI));
    chk("R8 req_ready_o", ready, int'(mbusy == 0));
    chk("R2 R4 R5 R8 bus_cmd_o", bcmd, mbusy ? mcmd : 0);
    if (mbusy != 0) chk("R8 bus_idx_o", bidx, midx);
    chk("R2 req_done_o", done, mdone);
    for (int i = 0; i < NL; i++) chk("R3 R4 R5 R6 R7 line state", line(i), mst[i]);
  endtask

  task automatic model_update();
    int nst[NL];
    int e;
    int nd = 0;
    for (int i = 0; i < NL; i++) nst[i] = mst[i];
    if (sv) nst[sidx] = snp_next(mst[sidx], int'(scmd));
    if (mbusy == 0 && rv) begin
      e = nst[ridx];
      case (rop)
        2'd1: begin
          if (e == SM || e == SE) begin nst[ridx] = SM; nd = 1; end
          else begin mbusy = 1; midx = ridx; mcmd = (e == SI) ? 2 : 3; end
        end
        2'd2: begin
          if (e == SM || e == SO) begin mbusy = 1; midx = ridx; mcmd = 4; end
          else begin nst[ridx] = SI; nd = 1; end
        end
        default: begin
          if (e == SI) begin mbusy = 1; midx = ridx; mcmd = 1; end
          else nd = 1;
        end
      endcase
    end else if (mbusy != 0 && gnt) begin
      case (mcmd)
        1: nst[midx] = shr ? SS : SE;
        2, 3: nst[midx] = SM;
        default: nst[midx] = SI;
      endcase
      mbusy = 0; nd = 1;
    end else if (mbusy != 0 && sv && sidx == midx && nst[midx] == SI) begin
      if (mcmd == 3) mcmd = 2;
      else if (mcmd == 4) begin mbusy = 0; nd = 1; end
    end
    for (int i = 0; i < NL; i++) mst[i] = nst[i];
    mdone = nd;
  endtask

  task automatic step(input bit v, input int op, input int idx,
                      input bit s, input int sc, input int si,
                      input bit g, input bit sh);
    @(negedge clk);
    rv = v; rop = 2'(op); ridx = IW'(idx);
    sv = s; scmd = 3'(sc); sidx = IW'(si);
    gnt = g; shr = sh;
    #1 compare_all();
    @(posedge clk);
    model_update();
    #2;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) mst[i] = SI;
    mbusy = 0; mcmd = 0; midx = 0; mdone = 0;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NL; i++) chk("R1 reset line state", line(i), SI);
    chk("R1 reset bus_cmd_o", bcmd, 0);
    chk("R1 reset req_ready_o", ready, 1);
    chk("R1 reset req_done_o", done, 0);

    // R2 read miss, no sharer -> E
    step(1, 0, 1, 0, 0, 0, 0, 0);
    chk("R2 read miss posts bus read", bcmd, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 read miss unshared -> E", line(1), SE);
    chk("R2 done after grant", done, 1);
    // R3 silent E->M
    step(1, 1, 1, 0, 0, 0, 0, 0);
    chk("R3 write E -> M", line(1), SM);
    chk("R3 no bus command", bcmd, 0);
    // R6 snoop read on M
    step(0, 0, 0, 1, 1, 1, 0, 0);
    chk("R6 snoop read M -> O", line(1), SO);
    // R4 write on O -> upgrade
    step(1, 1, 1, 0, 0, 0, 0, 0);
    chk("R4 write O posts upgrade", bcmd, 3);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 upgrade grant -> M", line(1), SM);
    // R2 read miss shared -> S
    step(1, 0, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    chk("R2 read miss shared -> S", line(2), SS);
    // R7 snoop rdx on S
    step(0, 0, 0, 1, 2, 2, 0, 0);
    chk("R7 snoop rdx S -> I", line(2), SI);
    // R5 evict M -> writeback
    step(1, 2, 1, 0, 0, 0, 0, 0);
    chk("R5 evict M posts writeback", bcmd, 4);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R5 writeback grant -> I", line(1), SI);

    // R9 upgrade turned into read-exclusive
    step(1, 0, 3, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 1, 3, 0, 0, 0, 0, 0);
    chk("R9 upgrade posted", bcmd, 3);
    // R8 request ignored while busy
    step(1, 2, 5, 0, 0, 0, 0, 0);
    chk("R8 busy ignores request", bidx, 3);
    step(0, 0, 0, 1, 3, 3, 0, 0);
    chk("R9 upgrade becomes read-exclusive", bcmd, 2);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    chk("R9 line M after rdx grant", line(3), SM);
    // R9 writeback stays on downgrade, cancels on invalidate
    step(1, 2, 3, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 3, 0, 0);
    chk("R9 writeback kept after M -> O", bcmd, 4);
    chk("R9 line O during writeback", line(3), SO);
    step(0, 0, 0, 1, 2, 3, 0, 0);
    chk("R9 writeback withdrawn", bcmd, 0);
    chk("R9 withdrawn writeback completes", done, 1);

    // R10 same-cycle snoop read then local write: E->S, so upgrade
    step(1, 0, 4, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 4, 1, 1, 4, 0, 0);
    chk("R10 snoop first -> upgrade", bcmd, 3);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    // R7 writeback snoop no effect
    step(0, 0, 0, 1, 4, 4, 0, 0);
    chk("R7 snooped writeback no effect", line(4), SM);
    idle();

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      bit g, s;
      g = (mbusy != 0) && ($urandom % 3 == 0);
      s = !g && ($urandom % 3 == 0);
      step($urandom % 2 == 0, $urandom % 3, ($urandom % 2) ? $urandom % 3 : $urandom % NL,
           s, $urandom % 5, ($urandom % 2) ? $urandom % 3 : $urandom % NL,
           g, $urandom % 2 == 0);
    end
    idle();
    finish_run();
  end
endmodule